// File: doc/BRIEF.md
# Dual-Polarity Pulse Width Meter

This block measures how long a single digital input stays high and how long it stays low. The input is resynchronised to the system clock. It then drives two measurement channels of opposite polarity. The high channel counts prescaled clock ticks while the synchronised level is high. The low channel counts them while the level is low. When a channel's level ends, its running count is copied into a capture register and the count is cleared. Software reads the two captured widths and works out the pulse period and duty from them.

Each polarity also has an interrupt request. The high-side request pulses on each rising transition of the synchronised input. The low-side request pulses on each falling transition. Each request fires in the same cycle that the opposite channel's capture register takes its new value. A single enable input holds the whole block inactive while it is clear. Counts saturate rather than wrap, and each capture carries an overflow flag.

Top module: `pulse_width_meter`

## Requirements
- R1: After reset, both widths, both overflow flags and both interrupt requests are 0.
- R2: `hi_irq` is high for exactly one clock, starting right after the third rising clock edge that samples `pwd_in` high following a low level (two synchroniser flops plus one edge register).
- R3: `lo_irq` is high for exactly one clock, starting right after the third rising clock edge that samples `pwd_in` low following a high level.
- R4: If `pwd_in` is sampled high on H consecutive clock edges, then `hi_width` becomes floor(H / PRESCALE), where PRESCALE is the number of clocks per count tick. It is updated on the same edge at which `lo_irq` rises.
- R5: If `pwd_in` is sampled low on L consecutive edges after a high level, then `lo_width` becomes floor(L / PRESCALE). It is updated on the same edge at which `hi_irq` rises.
- R6: A count stops at 2^CNT_W-1. If a further tick arrives during the same level, the overflow flag (`hi_ovf` or `lo_ovf`) is captured as 1 together with the saturated width. Otherwise that flag is captured as 0.
- R7: Captured widths and overflow flags keep their values between captures.
- R8: Once `pwd_en` is sampled low, all outputs read 0 from the next edge on. While the block is disabled, changes on `pwd_in` raise no interrupt request.
- R9: `hi_irq` and `lo_irq` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwd_en | input | 1 | Demodulation enable; while clear, everything is held at 0 |
| pwd_in | input | 1 | Asynchronous input whose high and low times are measured |
| hi_width | output | CNT_W | Captured tick count of the last high level |
| lo_width | output | CNT_W | Captured tick count of the last low level |
| hi_ovf | output | 1 | The last high level saturated the count |
| lo_ovf | output | 1 | The last low level saturated the count |
| hi_irq | output | 1 | One-clock request on a rising input transition |
| lo_irq | output | 1 | One-clock request on a falling input transition |

## Verification
An input change that first shows up at clock edge k produces its interrupt pulse and the opposite channel's capture after edge k+2, that is, three registers later. The bench drives `pwd_in` on falling clock edges. It counts falling edges from the change and checks the request low at the second of them. It checks the request and the new capture at the third, and checks that the capture is still unchanged at the end of the level. When `pwd_en` drops, the cleared outputs are checked one edge later. The bench sweeps every level length from 3 to 40 clocks in a 6-bit, divide-by-4 configuration, and uses long levels on either side of saturation.

// File: rtl/pwdm_pkg.sv
// Shared constants for the pulse width meter.
// Assumes exactly two channels: index 0 measures high time, index 1 low time.
package pwdm_pkg;
    localparam int NUM_CH  = 2;
    localparam int CH_HIGH = 0;
    localparam int CH_LOW  = 1;
endpackage

// File: rtl/pwdm_sync.sv
// Input resynchroniser with edge detection.
// Assumes din is asynchronous to clk; SYNC_STAGES >= 2.
// While en is clear the chain is flushed to 0, so enabling never sees a stale edge.
module pwdm_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   level_q;

    // shift the input through the synchroniser flops
    always_ff @(posedge clk) begin
        if (!rst_n || !en) chain <= '0;
        else               chain <= {chain[SYNC_STAGES-2:0], din};
    end

    // remember the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n || !en) level_q <= 1'b0;
        else               level_q <= chain[SYNC_STAGES-1];
    end

    assign level = chain[SYNC_STAGES-1];
    assign rise  = level & ~level_q;
    assign fall  = ~level & level_q;
endmodule

// File: rtl/pwdm_chan.sv
// One gated, prescaled, saturating width counter with a capture register.
// Assumes close is asserted only while gate is low (gate has just ended).
// It counts one tick for every PRESCALE consecutive clocks with gate high.
module pwdm_chan #(
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             gate,
    input  logic             close,
    output logic [CNT_W-1:0] width,
    output logic             ovf
);
    localparam int               PW       = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0]    PRE_LAST = PW'(PRESCALE - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [PW-1:0]    pre;
    logic [CNT_W-1:0] run;
    logic             run_ovf;

    // prescale, count while gated, saturate, and capture on close
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre     <= '0;
            run     <= '0;
            run_ovf <= 1'b0;
            width   <= '0;
            ovf     <= 1'b0;
        end else if (close) begin
            width   <= run;
            ovf     <= run_ovf;
            run     <= '0;
            run_ovf <= 1'b0;
            pre     <= '0;
        end else if (gate) begin
            if (pre == PRE_LAST) begin
                pre <= '0;
                if (run == CNT_MAX) run_ovf <= 1'b1;
                else                run     <= run + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end else begin
            pre <= '0;
        end
    end
endmodule

// File: rtl/pulse_width_meter.sv
// Top level: one input feeds a high-time channel and a low-time channel of
// opposite polarity, plus one interrupt request per input edge direction.
// Assumes a synchronous active-low reset and an asynchronous pwd_in.
module pulse_width_meter #(
    parameter int CNT_W       = 16,
    parameter int PRESCALE    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwd_en,
    input  logic             pwd_in,
    output logic [CNT_W-1:0] hi_width,
    output logic [CNT_W-1:0] lo_width,
    output logic             hi_ovf,
    output logic             lo_ovf,
    output logic             hi_irq,
    output logic             lo_irq
);
    import pwdm_pkg::*;

    logic                          level, rise, fall;
    logic [NUM_CH-1:0]             gate, close, ovf_v, irq_q;
    logic [NUM_CH-1:0][CNT_W-1:0]  width_v;

    pwdm_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .en(pwd_en), .din(pwd_in),
        .level(level), .rise(rise), .fall(fall)
    );

    // the true level gates the high channel, the inverted level gates the low one
    assign gate[CH_HIGH]  = level;
    assign close[CH_HIGH] = fall;
    assign gate[CH_LOW]   = ~level;
    assign close[CH_LOW]  = rise;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwdm_chan #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) chan_i (
            .clk(clk), .rst_n(rst_n), .en(pwd_en),
            .gate(gate[c]), .close(close[c]),
            .width(width_v[c]), .ovf(ovf_v[c])
        );
    end

    // one-clock requests on a rising edge of each channel's driving signal
    always_ff @(posedge clk) begin
        if (!rst_n || !pwd_en) irq_q <= '0;
        else                   irq_q <= {fall, rise};
    end

    assign hi_width = width_v[CH_HIGH];
    assign lo_width = width_v[CH_LOW];
    assign hi_ovf   = ovf_v[CH_HIGH];
    assign lo_ovf   = ovf_v[CH_LOW];
    assign hi_irq   = irq_q[CH_HIGH];
    assign lo_irq   = irq_q[CH_LOW];
endmodule

// File: rtl/pulse_width_meter_chk.sv
// Property checker for pulse_width_meter, attached by bind below.
module pulse_width_meter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwd_en,
    input logic [CNT_W-1:0] hi_width,
    input logic [CNT_W-1:0] lo_width,
    input logic             hi_ovf,
    input logic             lo_ovf,
    input logic             hi_irq,
    input logic             lo_irq
);
    localparam logic [CNT_W-1:0] WMAX = '1;

    // R2
    hi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_irq |=> !hi_irq);
    // R3
    lo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_irq |=> !lo_irq);
    // R4
    hi_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwd_en && $past(pwd_en) && !$stable(hi_width)) |-> lo_irq);
    // R5
    lo_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwd_en && $past(pwd_en) && !$stable(lo_width)) |-> hi_irq);
    // R6
    hi_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ovf |-> (hi_width == WMAX));
    // R6
    lo_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ovf |-> (lo_width == WMAX));
    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwd_en |=> (hi_width == '0 && lo_width == '0 && !hi_ovf && !lo_ovf
                     && !hi_irq && !lo_irq));
    // R9
    excl_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_irq && lo_irq));
endmodule

bind pulse_width_meter pulse_width_meter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pwd_en(pwd_en),
    .hi_width(hi_width), .lo_width(lo_width),
    .hi_ovf(hi_ovf), .lo_ovf(lo_ovf),
    .hi_irq(hi_irq), .lo_irq(lo_irq)
);

// File: tb/pulse_width_meter_tb_top.sv
`timescale 1ns/1ps
module pulse_width_meter_tb_top;
    localparam int W   = 6;
    localparam int P   = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwd_en = 1'b0;
    logic         pwd_in = 1'b0;
    logic [W-1:0] hi_width, lo_width;
    logic         hi_ovf, lo_ovf, hi_irq, lo_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int prev_dur = -1;

    always #2 clk = ~clk;

    pulse_width_meter #(.CNT_W(W), .PRESCALE(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwd_en(pwd_en), .pwd_in(pwd_in),
        .hi_width(hi_width), .lo_width(lo_width),
        .hi_ovf(hi_ovf), .lo_ovf(lo_ovf),
        .hi_irq(hi_irq), .lo_irq(lo_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_w(input int d);
        return (d / P > MAXV) ? MAXV : d / P;
    endfunction

    function automatic int exp_o(input int d);
        return (d / P > MAXV) ? 1 : 0;
    endfunction

    // hold pwd_in at lvl for dur clock edges (dur >= 3) and check the
    // request and the capture of the previous level at the third edge
    task automatic phase(input logic lvl, input int dur);
        pwd_in = lvl;
        for (int i = 1; i <= dur; i++) begin
            @(negedge clk);
            if (i == 2) begin
                if (lvl) chk("R2 hi_irq early", int'(hi_irq), 0);
                else     chk("R3 lo_irq early", int'(lo_irq), 0);
            end
            if (i == 3) begin
                if (lvl) begin
                    chk("R2 hi_irq", int'(hi_irq), 1);
                    chk("R9 lo_irq quiet", int'(lo_irq), 0);
                    if (prev_dur >= 0) begin
                        chk("R5 lo_width", int'(lo_width), exp_w(prev_dur));
                        chk("R6 lo_ovf", int'(lo_ovf), exp_o(prev_dur));
                    end
                end else begin
                    chk("R3 lo_irq", int'(lo_irq), 1);
                    chk("R9 hi_irq quiet", int'(hi_irq), 0);
                    chk("R4 hi_width", int'(hi_width), exp_w(prev_dur));
                    chk("R6 hi_ovf", int'(hi_ovf), exp_o(prev_dur));
                end
            end
            if (i == 4) begin
                if (lvl) chk("R2 hi_irq one clock", int'(hi_irq), 0);
                else     chk("R3 lo_irq one clock", int'(lo_irq), 0);
            end
            if (i == dur && prev_dur >= 0) begin
                if (lvl) chk("R7 lo_width held", int'(lo_width), exp_w(prev_dur));
                else     chk("R7 hi_width held", int'(hi_width), exp_w(prev_dur));
            end
        end
        prev_dur = dur;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 hi_width", int'(hi_width), 0);
        chk("R1 lo_width", int'(lo_width), 0);
        chk("R1 irqs", int'({hi_irq, lo_irq}), 0);
        chk("R1 ovfs", int'({hi_ovf, lo_ovf}), 0);
        rst_n = 1'b1;

        // R8 disabled: toggling the input raises nothing
        for (int i = 0; i < 12; i++) begin
            pwd_in = i[1];
            @(negedge clk);
            chk("R8 disabled irqs", int'({hi_irq, lo_irq}), 0);
        end
        pwd_in = 1'b0;
        pwd_en = 1'b1;
        repeat (5) @(negedge clk);

        // sweep every high and low length from 3 to 40
        prev_dur = -1;
        for (int h = 3; h <= 40; h++) begin
            phase(1'b1, h);
            phase(1'b0, 43 - h);
        end
        // around saturation: 255 fits, 256 and above saturate (R6)
        phase(1'b1, 255);
        phase(1'b0, 256);
        phase(1'b1, 256);
        phase(1'b0, 255);
        phase(1'b1, 300);
        phase(1'b0, 7);
        phase(1'b1, 5);

        // R8 drop enable: outputs cleared one edge later
        pwd_en = 1'b0;
        @(negedge clk);
        chk("R8 hi_width cleared", int'(hi_width), 0);
        chk("R8 lo_width cleared", int'(lo_width), 0);
        chk("R8 ovf/irq cleared", int'({hi_ovf, lo_ovf, hi_irq, lo_irq}), 0);
        pwd_in = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk("R8 no irq while disabled", int'({hi_irq, lo_irq}), 0);
        end
        finish_run();
    end
endmodule